// File: doc/BRIEF.md
# Streaming 2/6 Row Wavelet Stage

This block performs one horizontal level of a 2/6 wavelet decomposition on a stream of image pixels. Pixels arrive one per accepted cycle, flagged by a valid bit, with a start-of-line flag on the first pixel of a row and an end-of-line flag on the last. Every two accepted pixels form a pair. For each pair the stage produces one low-band coefficient, which is the floor of the pair average, and one high-band coefficient. The high-band value is the pair difference, corrected by the sums of the pairs on either side of it, so it looks at six pixels in total.

The high-band value then passes through a deadband and a divider. Small coefficients are forced to zero and the rest are scaled down, which makes that band sparse before any later coding. The low band is left exact. Feeding the low band of one stage into a second and a third stage gives an image at one-eighth scale. Each stage holds only the pair being finished, the pair waiting for its right neighbour and one earlier pair sum. It never needs a row or frame buffer.

Top module: `wv26_row_stage`

## Requirements
- R1: While reset is asserted, and on the first edge after it, `lo_vld_o` and `hi_vld_o` are 0. Before any pair has completed they stay 0.
- R2: For a pair (a, b), where a is the earlier pixel, `lo_o` = floor((a + b) / 2) and never exceeds PIX_W bits.
- R3: For a pair k that has both neighbours in its line, with s = a + b, the unquantized high value is (a − b) + floor((s[k+1] − s[k−1] + 4) / 8). The 8-wide floor division is an arithmetic right shift by 3.
- R4: The first and last pair of a line mirror the missing neighbour sum onto the existing one, so their correction term is 0 and the high value is a − b. A line of one pair is both first and last.
- R5: `hi_o` is two's complement and PIX_W+2 bits wide. It holds the extreme results without wrapping: +5119 and −5119 at PIX_W = 12.
- R6: A high value h with |h| < `dz_thr_i` is output as 0.
- R7: When |h| ≥ `dz_thr_i`, the output is sign(h) · floor(|h| / `q_step_i`), which rounds toward zero and keeps the sign. A step of 0 acts as 1. With a threshold of 0 and a step of 1, h passes unchanged.
- R8: Pair k's coefficients appear, with both valid flags high for one cycle, after the edge that accepts the second pixel of pair k+1. If pair k's second pixel carries end-of-line, they appear after the edge following that pixel. There is exactly one output per pair.
- R9: Cycles with the valid input low have no effect, whatever the pixel or flag values. End-of-line on the first pixel of a pair is ignored.
- R10: Start-of-line on an accepted pixel discards any half-built pair and any pending pair of an unfinished line, which then produce no output. That pixel becomes the first of a new line.
- R11: After reset, and after a pair that carries end-of-line, the next pair begins a new line even without a start-of-line flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_vld_i | input | 1 | Pixel accepted this cycle |
| pix_sol_i | input | 1 | Pixel is the first of a line |
| pix_eol_i | input | 1 | Pixel is the last of a line (honoured on the second pixel of a pair) |
| pix_i | input | PIX_W | Unsigned pixel value |
| dz_thr_i | input | PIX_W+2 | Deadband threshold on high-band magnitude |
| q_step_i | input | PIX_W+2 | Quantizer divisor for the high band (0 treated as 1) |
| lo_vld_o | output | 1 | Low-band coefficient valid |
| lo_o | output | PIX_W | Low-band coefficient |
| hi_vld_o | output | 1 | High-band coefficient valid |
| hi_o | output | PIX_W+2 | Quantized high-band coefficient, signed |

## Verification
A pair's results are due on the edge that accepts the second pixel of the next pair of the same line. The last pair of a line is due one edge after its own second pixel, so idle cycles or gaps in the stream delay the output without changing its value. The bench drives each input set 1 ns after a rising edge and updates its queue-based model of the current line at that moment. One nanosecond after the next rising edge it compares both valid flags, and both coefficients whenever a result is due. Every cycle is compared, so an output that arrives early, late, twice or not at all shows up as a mismatch on the exact cycle.

// File: rtl/wv26_pkg.sv
`timescale 1ns/1ps
package wv26_pkg;

    // Pair assembly phase: waiting for the first or the second pixel of a pair.
    typedef enum logic {
        PH_EMPTY = 1'b0,
        PH_HALF  = 1'b1
    } pair_phase_e;

    // High-band correction: (right sum - left sum + bias) >>> shift.
    localparam int unsigned CORR_BIAS  = 4;
    localparam int unsigned CORR_SHIFT = 3;

endpackage

// File: rtl/wv26_pair_gather.sv
`timescale 1ns/1ps
module wv26_pair_gather
    import wv26_pkg::*;
#(
    parameter  int unsigned PIX_W = 12,
    localparam int unsigned SUM_W = PIX_W + 1
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    vld_i,
    input  logic                    sol_i,
    input  logic                    eol_i,
    input  logic [PIX_W-1:0]        pix_i,
    output logic                    pair_vld_o,
    output logic [SUM_W-1:0]        pair_sum_o,
    output logic signed [SUM_W-1:0] pair_diff_o,
    output logic                    pair_first_o,
    output logic                    pair_last_o
);

    typedef struct packed {
        pair_phase_e      phase;
        logic [PIX_W-1:0] held;
        logic             line_new;
    } gather_t;

    gather_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        pair_vld_o   = 1'b0;
        pair_sum_o   = {1'b0, st_q.held} + {1'b0, pix_i};
        pair_diff_o  = $signed({1'b0, st_q.held}) - $signed({1'b0, pix_i});
        pair_first_o = st_q.line_new;
        pair_last_o  = eol_i;
        if (vld_i) begin
            if (sol_i) begin
                // A line start always opens a fresh pair.
                st_d.phase    = PH_HALF;
                st_d.held     = pix_i;
                st_d.line_new = 1'b1;
            end else if (st_q.phase == PH_EMPTY) begin
                // First pixel of a pair; an end-of-line flag here is ignored.
                st_d.phase = PH_HALF;
                st_d.held  = pix_i;
            end else begin
                pair_vld_o    = 1'b1;
                st_d.phase    = PH_EMPTY;
                st_d.line_new = eol_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.phase    <= PH_EMPTY;
            st_q.held     <= '0;
            st_q.line_new <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R8: a pair needs two accepted pixels, so two completions never touch.
    assert_pair_spacing_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pair_vld_o |=> !pair_vld_o);

endmodule

// File: rtl/wv26_highpass_lift.sv
`timescale 1ns/1ps
module wv26_highpass_lift
    import wv26_pkg::*;
#(
    parameter  int unsigned PIX_W = 12,
    localparam int unsigned SUM_W = PIX_W + 1,
    localparam int unsigned HI_W  = PIX_W + 2,
    localparam int unsigned EXT_W = SUM_W + 2
) (
    input  logic signed [SUM_W-1:0] diff_i,
    input  logic [SUM_W-1:0]        sum_left_i,
    input  logic [SUM_W-1:0]        sum_right_i,
    output logic signed [HI_W-1:0]  hi_o
);

    logic signed [EXT_W-1:0] delta;
    logic signed [EXT_W-1:0] corr;

    always_comb begin
        delta = $signed({2'b00, sum_right_i}) - $signed({2'b00, sum_left_i})
              + $signed(EXT_W'(CORR_BIAS));
        corr  = delta >>> CORR_SHIFT;
        hi_o  = $signed({diff_i[SUM_W-1], diff_i}) + $signed(corr[HI_W-1:0]);
    end

endmodule

// File: rtl/wv26_deadband_quant.sv
`timescale 1ns/1ps
module wv26_deadband_quant #(
    parameter int unsigned HI_W = 14
) (
    input  logic signed [HI_W-1:0] hi_i,
    input  logic [HI_W-1:0]        thr_i,
    input  logic [HI_W-1:0]        step_i,
    output logic signed [HI_W-1:0] q_o
);

    logic            neg;
    logic [HI_W-1:0] mag;
    logic [HI_W-1:0] divisor;
    logic [HI_W-1:0] quo;
    logic [HI_W-1:0] out_mag;

    always_comb begin
        neg     = hi_i[HI_W-1];
        mag     = neg ? (~hi_i + 1'b1) : hi_i;
        divisor = (step_i == '0) ? HI_W'(1) : step_i;
        quo     = mag / divisor;
        if (mag < thr_i) begin
            q_o = '0;
        end else begin
            q_o = neg ? (~quo + 1'b1) : quo;
        end
    end

    always_comb begin
        out_mag = q_o[HI_W-1] ? (~q_o + 1'b1) : q_o;
        // R7: quantizing never enlarges a coefficient.
        assert_no_growth_R7: assert (out_mag <= mag);
        // R7: a surviving coefficient keeps the sign it came in with.
        if (q_o != '0) begin
            assert_sign_kept_R7: assert (q_o[HI_W-1] == neg);
        end
    end

endmodule

// File: rtl/wv26_row_stage.sv
`timescale 1ns/1ps
module wv26_row_stage
    import wv26_pkg::*;
#(
    parameter  int unsigned PIX_W = 12,
    localparam int unsigned SUM_W = PIX_W + 1,
    localparam int unsigned HI_W  = PIX_W + 2
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   pix_vld_i,
    input  logic                   pix_sol_i,
    input  logic                   pix_eol_i,
    input  logic [PIX_W-1:0]       pix_i,
    input  logic [HI_W-1:0]        dz_thr_i,
    input  logic [HI_W-1:0]        q_step_i,
    output logic                   lo_vld_o,
    output logic [PIX_W-1:0]       lo_o,
    output logic                   hi_vld_o,
    output logic signed [HI_W-1:0] hi_o
);

    typedef struct packed {
        logic              cur_vld;
        logic              cur_first;
        logic              cur_last;
        logic [SUM_W-1:0]  cur_sum;
        logic [SUM_W-1:0]  cur_diff;
        logic [SUM_W-1:0]  prev_sum;
        logic              out_vld;
        logic [PIX_W-1:0]  out_lo;
        logic [HI_W-1:0]   out_hi;
    } stage_t;

    stage_t st_d, st_q;

    logic                    pair_vld;
    logic [SUM_W-1:0]        pair_sum;
    logic signed [SUM_W-1:0] pair_diff;
    logic                    pair_first;
    logic                    pair_last;

    logic                    flush;
    logic                    advance;
    logic [SUM_W-1:0]        left_s;
    logic [SUM_W-1:0]        right_s;
    logic signed [HI_W-1:0]  hi_raw;
    logic signed [HI_W-1:0]  hi_qnt;

    wv26_pair_gather #(.PIX_W(PIX_W)) i_gather (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .vld_i        (pix_vld_i),
        .sol_i        (pix_sol_i),
        .eol_i        (pix_eol_i),
        .pix_i        (pix_i),
        .pair_vld_o   (pair_vld),
        .pair_sum_o   (pair_sum),
        .pair_diff_o  (pair_diff),
        .pair_first_o (pair_first),
        .pair_last_o  (pair_last)
    );

    // Neighbour selection with mirroring at both line edges.
    always_comb begin
        flush   = st_q.cur_vld && st_q.cur_last;
        advance = pair_vld && st_q.cur_vld && !st_q.cur_last && !pair_first;
        if (flush) begin
            right_s = st_q.cur_first ? st_q.cur_sum : st_q.prev_sum;
        end else begin
            right_s = pair_sum;
        end
        left_s = st_q.cur_first ? right_s : st_q.prev_sum;
    end

    wv26_highpass_lift #(.PIX_W(PIX_W)) i_lift (
        .diff_i      ($signed(st_q.cur_diff)),
        .sum_left_i  (left_s),
        .sum_right_i (right_s),
        .hi_o        (hi_raw)
    );

    wv26_deadband_quant #(.HI_W(HI_W)) i_quant (
        .hi_i   (hi_raw),
        .thr_i  (dz_thr_i),
        .step_i (q_step_i),
        .q_o    (hi_qnt)
    );

    always_comb begin
        st_d         = st_q;
        st_d.out_vld = 1'b0;
        if (flush || advance) begin
            st_d.out_vld = 1'b1;
            st_d.out_lo  = st_q.cur_sum[SUM_W-1:1];
            st_d.out_hi  = hi_qnt;
        end
        if (flush) begin
            st_d.cur_vld = 1'b0;
        end
        if (pair_vld) begin
            // A pair that opens a line drops whatever was pending.
            st_d.cur_vld   = 1'b1;
            st_d.cur_first = pair_first;
            st_d.cur_last  = pair_last;
            st_d.cur_sum   = pair_sum;
            st_d.cur_diff  = pair_diff;
            st_d.prev_sum  = st_q.cur_sum;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lo_vld_o = st_q.out_vld;
    assign hi_vld_o = st_q.out_vld;
    assign lo_o     = st_q.out_lo;
    assign hi_o     = st_q.out_hi;

    // R1: outputs are quiet on the edge after reset is seen.
    assert_reset_quiet_R1: assert property (@(posedge clk_i)
        !rst_ni |=> (!lo_vld_o && !hi_vld_o));

    // R8: a line's final flush never coincides with a newly completed pair.
    assert_no_flush_clash_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(pair_vld && flush));

    // R8: an output is always caused by a completed pair or a flush one cycle earlier.
    assert_out_has_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lo_vld_o |-> ($past(pair_vld) || $past(flush)));

    // R4: at a line edge the lifting result is the bare pair difference.
    assert_edge_bare_diff_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((flush || advance) && (st_q.cur_first || st_q.cur_last))
        |-> (hi_raw == $signed({st_q.cur_diff[SUM_W-1], st_q.cur_diff})));

endmodule

// File: tb/test_wv26_row_stage.sv
`timescale 1ns/1ps
module test_wv26_row_stage;

    localparam int PW = 12;
    localparam int HW = PW + 2;
    localparam int WATCHDOG_CYCLES = 50000;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 vld, sol, eol;
    logic [PW-1:0]        pix;
    logic                 lo_vld, hi_vld;
    logic [PW-1:0]        lo;
    logic signed [HW-1:0] hi;

    int thr_v  = 0;
    int step_v = 1;

    wire [HW-1:0] thr_w  = HW'(thr_v);
    wire [HW-1:0] step_w = HW'(step_v);

    always #2 clk = ~clk;

    wv26_row_stage #(.PIX_W(PW)) i_wv26_row_stage (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .pix_vld_i (vld),
        .pix_sol_i (sol),
        .pix_eol_i (eol),
        .pix_i     (pix),
        .dz_thr_i  (thr_w),
        .q_step_i  (step_w),
        .lo_vld_o  (lo_vld),
        .lo_o      (lo),
        .hi_vld_o  (hi_vld),
        .hi_o      (hi)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string req_tag = "R1";

    // Behavioural model of the current line.
    int line_s[$];
    int line_d[$];
    int half_have = 0;
    int half_pix  = 0;
    int flush_due = 0;
    int exp_vld = 0, exp_lo = 0, exp_hi = 0;
    int rnd = 32'h1234_5677;

    function automatic int next_pix();
        rnd = (rnd * 1103515245 + 12345) & 32'h7fff_ffff;
        return (rnd >> 8) % (1 << PW);
    endfunction

    function automatic int quant(int h);
        int mag = (h < 0) ? -h : h;
        int st  = (step_v == 0) ? 1 : step_v;
        int q;
        if (mag < thr_v) return 0;
        q = mag / st;
        return (h < 0) ? -q : q;
    endfunction

    function automatic void expect_pair(int k, bit ended);
        bit first = (k == 0);
        bit last  = ended && (k == line_s.size() - 1);
        int corr  = 0;
        if (!first && !last) corr = (line_s[k+1] - line_s[k-1] + 4) >>> 3;
        exp_vld = 1;
        exp_lo  = line_s[k] / 2;
        exp_hi  = quant(line_d[k] + corr);
    endfunction

    function automatic void model(bit v, bit s, bit e, int p);
        exp_vld = 0;
        if (flush_due != 0) begin
            expect_pair(line_s.size() - 1, 1'b1);
            line_s.delete();
            line_d.delete();
            flush_due = 0;
        end
        if (v) begin
            if (s) begin
                line_s.delete();
                line_d.delete();
                half_have = 1;
                half_pix  = p;
            end else if (half_have == 0) begin
                half_have = 1;
                half_pix  = p;
            end else begin
                half_have = 0;
                line_s.push_back(half_pix + p);
                line_d.push_back(half_pix - p);
                if (line_s.size() >= 2) expect_pair(line_s.size() - 2, 1'b0);
                if (e) flush_due = 1;
            end
        end
    endfunction

    task automatic check_now();
        bit bad;
        n_cmp++;
        bad = (lo_vld !== 1'(exp_vld)) || (hi_vld !== 1'(exp_vld));
        if (exp_vld != 0 && !bad) bad = (int'(lo) != exp_lo) || (int'(hi) != exp_hi);
        if (bad) begin
            n_bad++;
            $display("FAIL %s: got vld=%0d/%0d lo=%0d hi=%0d, expected vld=%0d lo=%0d hi=%0d",
                     req_tag, lo_vld, hi_vld, lo, hi, exp_vld, exp_lo, exp_hi);
        end
    endtask

    task automatic cyc(input bit v, input bit s, input bit e, input int p);
        vld = v; sol = s; eol = e; pix = PW'(p);
        model(v, s, e, p);
        @(posedge clk);
        #1;
        check_now();
    endtask

    task automatic send_list(input int px[$], input bit with_sol);
        foreach (px[i]) cyc(1'b1, with_sol && (i == 0), i == px.size() - 1, px[i]);
        cyc(1'b0, 1'b0, 1'b0, 0);
        cyc(1'b0, 1'b0, 1'b0, 0);
    endtask

    task automatic send_rand(input int npix, input bit with_sol, input bit gaps);
        for (int i = 0; i < npix; i++) begin
            cyc(1'b1, with_sol && (i == 0), i == npix - 1, next_pix());
            // R9: idle cycles carry garbage data and both flags.
            if (gaps && (i % 3 == 1)) cyc(1'b0, 1'b1, 1'b1, next_pix());
        end
        cyc(1'b0, 1'b0, 1'b0, 0);
        cyc(1'b0, 1'b0, 1'b0, 0);
    endtask

    initial begin
        #(WATCHDOG_CYCLES * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL R8 watchdog: run exceeded %0d cycles, expected completion", WATCHDOG_CYCLES);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int px[$];
        rst_n = 1'b0; vld = 0; sol = 0; eol = 0; pix = '0;
        // R1: reset state
        req_tag = "R1";
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            #1;
            exp_vld = 0;
            check_now();
        end
        rst_n = 1'b1;
        cyc(1'b0, 1'b0, 1'b0, 0);

        // R11: first line after reset has no start flag
        req_tag = "R11";
        send_rand(10, 1'b0, 1'b0);

        // R2: low band averages on a ramp
        req_tag = "R2";
        px = {};
        for (int i = 0; i < 16; i++) px.push_back(i * 257 + 1);
        send_list(px, 1'b1);

        // R3: interior six-pixel correction on random data
        req_tag = "R3";
        send_rand(24, 1'b1, 1'b0);
        send_rand(30, 1'b1, 1'b0);

        // R4: single-pair line and strong edges
        req_tag = "R4";
        send_list('{4000, 3}, 1'b1);
        send_list('{0, 4095, 4095, 0, 17, 900}, 1'b1);

        // R5: extreme high-band values, positive then negative
        req_tag = "R5";
        send_list('{0, 0, 4095, 0, 4095, 4095, 0, 0}, 1'b1);
        send_list('{4095, 4095, 0, 4095, 0, 0, 4095, 4095}, 1'b1);

        // R6: deadband
        req_tag = "R6";
        thr_v = 300; step_v = 1;
        send_rand(20, 1'b1, 1'b0);
        thr_v = 1500;
        send_rand(20, 1'b1, 1'b0);

        // R7: quantizer step, then step 0 behaving as 1
        req_tag = "R7";
        thr_v = 10; step_v = 7;
        send_rand(20, 1'b1, 1'b0);
        send_list('{0, 4095, 4095, 4095, 0, 0, 4095, 0}, 1'b1);
        thr_v = 0; step_v = 0;
        send_rand(12, 1'b1, 1'b0);
        step_v = 1;

        // R8: gapped stream; output timing follows the pixel acceptances
        req_tag = "R8";
        send_rand(18, 1'b1, 1'b1);
        send_rand(2, 1'b1, 1'b1);

        // R9: end-of-line on a pair's first pixel is ignored
        req_tag = "R9";
        cyc(1'b1, 1'b1, 1'b0, next_pix());
        cyc(1'b1, 1'b0, 1'b0, next_pix());
        cyc(1'b1, 1'b0, 1'b1, next_pix());
        cyc(1'b0, 1'b1, 1'b1, next_pix());
        cyc(1'b1, 1'b0, 1'b0, next_pix());
        cyc(1'b1, 1'b0, 1'b0, next_pix());
        cyc(1'b1, 1'b0, 1'b1, next_pix());
        cyc(1'b0, 1'b0, 1'b0, 0);
        cyc(1'b0, 1'b0, 1'b0, 0);

        // R10: line start mid-pair and mid-line discards pending work
        req_tag = "R10";
        for (int i = 0; i < 5; i++) cyc(1'b1, i == 0, 1'b0, next_pix());
        send_rand(8, 1'b1, 1'b0);
        for (int i = 0; i < 6; i++) cyc(1'b1, i == 0, 1'b0, next_pix());
        send_rand(6, 1'b1, 1'b0);

        // R11: back-to-back lines without start flags
        req_tag = "R11";
        send_rand(8, 1'b0, 1'b0);
        send_rand(4, 1'b0, 1'b0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule